// File: doc/BRIEF.md
# Reconfigurable Region Freeze Controller

This block sits between a host register bus and one reconfigurable region of logic. Software uses it to fence the region off before the region is rewritten, and to let traffic back in afterwards. Four 32-bit registers sit behind a small word-addressed slave port:

| Byte offset | Register | Access |
|---|---|---|
| 0 | done flags | read |
| 4 | request word | read and write |
| 8 | error flags | read, write 1 to clear |
| 12 | fixed identifier | read |

The block drives a `freeze_out` line that the gating logic around the region obeys, and a `region_rst_out` line that holds the region in reset. It receives a `settle_in` line that reports when traffic still in flight has drained.

The sequencer has five states:

- `ST_RUN`: traffic flows and the run-done flag is set.
- `ST_DRAIN`: freeze is driven and the block waits for the region to settle.
- `ST_FROZEN`: freeze is complete and the freeze-done flag is set.
- `ST_RELEASE`: the region reset is dropped while freeze is still held.
- `ST_RESUME`: freeze is dropped.

It moves between them as follows:

- `ST_RUN` to `ST_DRAIN`, when a freeze request is accepted.
- `ST_DRAIN` to `ST_FROZEN`, when the settle window is met.
- `ST_FROZEN` to `ST_RELEASE`, when an unfreeze request is accepted.
- `ST_RELEASE` to `ST_RESUME`, unconditionally.
- `ST_RESUME` to `ST_RUN`, unconditionally.

The expected software order is:

1. Request freeze.
2. Poll for freeze-done.
3. Request region reset.
4. Clear the request word.
5. Request unfreeze.
6. Poll for run-done.
7. Clear the request word.

A request that breaks this order is refused and recorded in the sticky error register.

Top module: `frz_ctrl_unit`

## Requirements
- R1: After reset the done register reads 2 (bit 1 run-done set, bit 0 freeze-done clear), the request and error registers read 0, and `freeze_out` and `region_rst_out` are low.
- R2: A read of byte offset 12 returns 0xAD000003. A read of any address with a bit at position 4 or above set returns 0. `bus_rdata` is 0 whenever `bus_rd` is low. Address bits 1:0 are ignored.
- R3: Writing request value 1 (bit 0, freeze) while in `ST_RUN` drives `freeze_out` high from the next cycle on, and the done register then reads 0.
- R4: Freeze-done (done bit 0) is set only after `settle_in` has been sampled high on SETTLE_CYC consecutive clock edges in `ST_DRAIN`. A low sample restarts the count.
- R5: Done bit 0 and done bit 1 are never both set.
- R6: `region_rst_out` equals request bit 1 while the state is `ST_FROZEN`, and is low in every other state.
- R7: An accepted unfreeze (request value 4, bit 2) drops `region_rst_out` at the next edge while `freeze_out` stays high. `freeze_out` falls one cycle later, and run-done is set one cycle after that.
- R8: A refused request leaves the state and the request register unchanged, and sets one bit in the error register. Bit 0 records a freeze outside `ST_RUN`. Bit 1 records a reset outside `ST_FROZEN`. Bit 2 records an unfreeze outside `ST_FROZEN`. Bit 3 records more than one of request bits 2:0 set.
- R9: Error bits stay set until a write to offset 8 with data bit 0 set clears the whole register. Reads, and writes with data bit 0 clear, leave it unchanged.
- R10: Writing 0 to the request register is always accepted, and it clears the region reset.
- R11: The request register reads back the bits 2:0 of the last accepted write, with all upper bits 0. Data bits 31:3 of a request write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| settle_in | input | 1 | Region has no traffic in flight |
| freeze_out | output | 1 | Gate traffic into and out of the region |
| region_rst_out | output | 1 | Hold the region in reset |

## Verification
The bench builds the block with SETTLE_CYC = 5 and AW = 6. The short settle window lets directed tests interrupt a partly filled window and reach the exact edge where freeze-done appears. The wider address lets reads land outside the four-word window and return 0. Under these values the random phase, whose writes are weighted towards freeze and unfreeze requests, passes through every state many times within a few thousand cycles.

// File: rtl/frz_pkg.sv
package frz_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_FROZEN  = 3'd2,
        ST_RELEASE = 3'd3,
        ST_RESUME  = 3'd4
    } frz_state_e;

    localparam int REQ_W  = 3;
    localparam int ERR_W  = 4;
    localparam int DATA_W = 32;

    // request word bit positions
    localparam int REQ_FREEZE   = 0;
    localparam int REQ_RESET    = 1;
    localparam int REQ_UNFREEZE = 2;

    // error register bit positions
    localparam int ERR_FREEZE   = 0;
    localparam int ERR_RESET    = 1;
    localparam int ERR_UNFREEZE = 2;
    localparam int ERR_MULTI    = 3;

    // word indices within the register window
    localparam logic [1:0] IDX_DONE  = 2'd0;
    localparam logic [1:0] IDX_REQ   = 2'd1;
    localparam logic [1:0] IDX_ERR   = 2'd2;
    localparam logic [1:0] IDX_IDENT = 2'd3;

    localparam logic [DATA_W-1:0] IDENT_WORD = 32'hAD00_0003;

endpackage

// File: rtl/frz_bus_decode.sv
module frz_bus_decode
    import frz_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        done_flags,
    input  logic [REQ_W-1:0]  req_word,
    input  logic [ERR_W-1:0]  err_word,
    output logic              wr_req,
    output logic              wr_err,
    output logic [DATA_W-1:0] rdata
);

    logic       in_window;
    logic [1:0] word_idx;

    assign in_window = ((addr >> 4) == '0);
    assign word_idx  = addr[3:2];

    assign wr_req = wr && in_window && (word_idx == IDX_REQ);
    assign wr_err = wr && in_window && (word_idx == IDX_ERR);

    always_comb begin
        rdata = '0;
        if (rd && in_window) begin
            unique case (word_idx)
                IDX_DONE:  rdata = {{(DATA_W-2){1'b0}}, done_flags};
                IDX_REQ:   rdata = {{(DATA_W-REQ_W){1'b0}}, req_word};
                IDX_ERR:   rdata = {{(DATA_W-ERR_W){1'b0}}, err_word};
                IDX_IDENT: rdata = IDENT_WORD;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/frz_req_check.sv
module frz_req_check
    import frz_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             wr_err,
    input  logic [REQ_W-1:0] req_in,
    input  logic             err_clr_bit,
    input  frz_state_e       state,
    output logic [REQ_W-1:0] req_q,
    output logic [ERR_W-1:0] err_q,
    output logic             go_freeze,
    output logic             go_unfreeze
);

    logic             multi;
    logic             in_run;
    logic             in_frozen;
    logic             is_freeze;
    logic             is_reset;
    logic             is_unfreeze;
    logic [ERR_W-1:0] err_set;
    logic             accept;

    assign multi = (req_in[0] & req_in[1]) | (req_in[0] & req_in[2]) | (req_in[1] & req_in[2]);

    assign in_run    = (state == ST_RUN);
    assign in_frozen = (state == ST_FROZEN);

    assign is_freeze   = !multi && req_in[REQ_FREEZE];
    assign is_reset    = !multi && req_in[REQ_RESET];
    assign is_unfreeze = !multi && req_in[REQ_UNFREEZE];

    always_comb begin
        err_set               = '0;
        err_set[ERR_MULTI]    = multi;
        err_set[ERR_FREEZE]   = is_freeze && !in_run;
        err_set[ERR_RESET]    = is_reset && !in_frozen;
        err_set[ERR_UNFREEZE] = is_unfreeze && !in_frozen;
    end

    assign accept      = wr_req && (err_set == '0);
    assign go_freeze   = accept && is_freeze;
    assign go_unfreeze = accept && is_unfreeze;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= req_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (wr_err && err_clr_bit) begin
            err_q <= '0;
        end else if (wr_req) begin
            err_q <= err_q | err_set;
        end
    end

endmodule

// File: rtl/frz_seq_fsm.sv
module frz_seq_fsm
    import frz_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_freeze,
    input  logic       go_unfreeze,
    input  logic       settle_in,
    input  logic       reset_req,
    output frz_state_e state,
    output logic       freeze_out,
    output logic       region_rst_out,
    output logic       done_frozen,
    output logic       done_run
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    frz_state_e       state_q;
    frz_state_e       state_d;
    logic [CNT_W-1:0] settle_cnt;
    logic             window_met;

    assign window_met = settle_in && (settle_cnt == CNT_LAST);

    // settle window counter, cleared outside the drain state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_cnt <= '0;
        end else if (state_q == ST_DRAIN && settle_in && !window_met) begin
            settle_cnt <= settle_cnt + 1'b1;
        end else begin
            settle_cnt <= '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (go_freeze) state_d = ST_DRAIN;
            ST_DRAIN:   if (window_met) state_d = ST_FROZEN;
            ST_FROZEN:  if (go_unfreeze) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        freeze_out     = 1'b0;
        region_rst_out = 1'b0;
        done_frozen    = 1'b0;
        done_run       = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                done_run = 1'b1;
            end
            ST_DRAIN: begin
                freeze_out = 1'b1;
            end
            ST_FROZEN: begin
                freeze_out     = 1'b1;
                done_frozen    = 1'b1;
                region_rst_out = reset_req;
            end
            ST_RELEASE: begin
                freeze_out = 1'b1;
            end
            ST_RESUME: begin
                freeze_out = 1'b0;
            end
            default: begin
                freeze_out = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/frz_ctrl_unit.sv
module frz_ctrl_unit
    import frz_pkg::*;
#(
    parameter int AW         = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              settle_in,
    output logic              freeze_out,
    output logic              region_rst_out
);

    logic                    wr_req;
    logic                    wr_err;
    logic [REQ_W-1:0]        req_q;
    logic [ERR_W-1:0]        err_q;
    logic                    go_freeze;
    logic                    go_unfreeze;
    logic                    done_frozen;
    logic                    done_run;
    frz_state_e              state;
    logic [DATA_W-REQ_W-1:0] wdata_unused_hi;

    assign wdata_unused_hi = bus_wdata[DATA_W-1:REQ_W];

    frz_bus_decode #(
        .AW(AW)
    ) u_decode (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .done_flags ({done_run, done_frozen}),
        .req_word   (req_q),
        .err_word   (err_q),
        .wr_req     (wr_req),
        .wr_err     (wr_err),
        .rdata      (bus_rdata)
    );

    frz_req_check u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_err      (wr_err),
        .req_in      (bus_wdata[REQ_W-1:0]),
        .err_clr_bit (bus_wdata[0]),
        .state       (state),
        .req_q       (req_q),
        .err_q       (err_q),
        .go_freeze   (go_freeze),
        .go_unfreeze (go_unfreeze)
    );

    frz_seq_fsm #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .go_freeze      (go_freeze),
        .go_unfreeze    (go_unfreeze),
        .settle_in      (settle_in),
        .reset_req      (req_q[REQ_RESET]),
        .state          (state),
        .freeze_out     (freeze_out),
        .region_rst_out (region_rst_out),
        .done_frozen    (done_frozen),
        .done_run       (done_run)
    );

endmodule

// File: rtl/frz_ctrl_checker.sv
module frz_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_req,
    input logic       wr_err,
    input logic [2:0] wdata_lo,
    input logic       go_freeze,
    input logic       done_frozen,
    input logic       done_run,
    input logic       freeze_out,
    input logic       region_rst_out,
    input logic [2:0] req_q,
    input logic [3:0] err_q
);

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_frozen && done_run)); // R5

    AST_FROZEN_HOLDS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        done_frozen |-> freeze_out); // R4

    AST_RST_ONLY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        region_rst_out |-> done_frozen); // R6

    AST_FREEZE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        go_freeze |=> (freeze_out && !done_run)); // R3

    AST_RESET_BEFORE_THAW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_out) |-> (!region_rst_out && $past(!region_rst_out) && !done_run)); // R7

    AST_RUN_AFTER_THAW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_out) |=> done_run); // R7

    AST_MULTI_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && $countones(wdata_lo) > 1) |=> $stable(req_q)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q != 4'd0) && !(wr_err && wdata_lo[0])) |=> (err_q != 4'd0)); // R9

endmodule

bind frz_ctrl_unit frz_ctrl_checker u_frz_ctrl_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_req         (wr_req),
    .wr_err         (wr_err),
    .wdata_lo       (bus_wdata[2:0]),
    .go_freeze      (go_freeze),
    .done_frozen    (done_frozen),
    .done_run       (done_run),
    .freeze_out     (freeze_out),
    .region_rst_out (region_rst_out),
    .req_q          (req_q),
    .err_q          (err_q)
);

// File: tb/frz_ctrl_unit_bench.sv
module frz_ctrl_unit_bench;

    localparam int CLK_P  = 10;
    localparam int AW     = 6;
    localparam int SETTLE = 5;
    localparam int WD_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        settle_in;
    logic        freeze_out;
    logic        region_rst_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model: 0 run, 1 drain, 2 frozen, 3 release, 4 resume
    int         m_st;
    int         m_cnt;
    logic [2:0] m_req;
    logic [3:0] m_err;

    always #(CLK_P/2) clk = ~clk;

    frz_ctrl_unit #(.AW(AW), .SETTLE_CYC(SETTLE)) u_frz_ctrl_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .settle_in      (settle_in),
        .freeze_out     (freeze_out),
        .region_rst_out (region_rst_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        if (a[5:4] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0:    return {30'h0, (m_st == 0), (m_st == 2)};
            2'd1:    return {29'h0, m_req};
            2'd2:    return {28'h0, m_err};
            default: return 32'hAD00_0003;
        endcase
    endfunction

    function automatic void model_reset();
        m_st = 0; m_cnt = 0; m_req = 3'd0; m_err = 4'd0;
    endfunction

    function automatic void model_step(input logic wr, input logic [5:0] a,
                                       input logic [31:0] d, input logic s);
        int         nst = m_st;
        logic [2:0] v   = d[2:0];
        // sequencer
        case (m_st)
            1: begin
                if (s && m_cnt == SETTLE - 1) begin nst = 2; m_cnt = 0; end
                else if (s) m_cnt = m_cnt + 1;
                else m_cnt = 0;
            end
            3: nst = 4;
            4: nst = 0;
            default: m_cnt = 0;
        endcase
        if (wr && a[5:4] == 2'b00 && a[3:2] == 2'd1) begin
            if ($countones(v) > 1) m_err[3] = 1'b1;
            else if (v == 3'd1) begin
                if (m_st == 0) begin m_req = v; nst = 1; m_cnt = 0; end
                else m_err[0] = 1'b1;
            end else if (v == 3'd2) begin
                if (m_st == 2) m_req = v; else m_err[1] = 1'b1;
            end else if (v == 3'd4) begin
                if (m_st == 2) begin m_req = v; nst = 3; end
                else m_err[2] = 1'b1;
            end else m_req = 3'd0;
        end
        if (wr && a[5:4] == 2'b00 && a[3:2] == 2'd2 && d[0]) m_err = 4'd0;
        m_st = nst;
    endfunction

    // one bus cycle: a write, or a read of address a checked before the edge
    task automatic cyc(input string tag, input logic wr, input logic [5:0] a,
                       input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d; settle_in = s;
        #1;
        if (!wr) chk(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        model_step(wr, a, d, s);
        #1;
        chk(tag, {31'h0, freeze_out}, {31'h0, (m_st == 1 || m_st == 2 || m_st == 3)});
        chk(tag, {31'h0, region_rst_out}, {31'h0, (m_st == 2 && m_req[1])});
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; settle_in = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {31'h0, freeze_out}, 32'h0);
        chk("R1", {31'h0, region_rst_out}, 32'h0);
        cyc("R1", 0, 6'd0, 0, 0);
        cyc("R1", 0, 6'd4, 0, 0);
        cyc("R1", 0, 6'd8, 0, 0);

        // identifier, out-of-window and idle reads
        cyc("R2", 0, 6'd12, 0, 0);
        cyc("R2", 0, 6'd15, 0, 0);
        cyc("R2", 0, 6'h2C, 0, 0);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_addr = 6'd12;
        #1;
        chk("R2", bus_rdata, 32'h0);
        @(posedge clk);
        model_step(0, 6'd12, 0, 0);

        // refused requests while running
        cyc("R8", 1, 6'd4, 32'd4, 0);
        cyc("R8", 1, 6'd4, 32'd2, 0);
        cyc("R8", 1, 6'd4, 32'd3, 0);
        cyc("R8", 0, 6'd8, 0, 0);
        cyc("R8", 0, 6'd0, 0, 0);
        cyc("R8", 0, 6'd4, 0, 0);

        // sticky error register
        cyc("R9", 1, 6'd8, 32'h2, 0);
        cyc("R9", 0, 6'd8, 0, 0);
        cyc("R9", 0, 6'd8, 0, 0);
        cyc("R9", 1, 6'd8, 32'h1, 0);
        cyc("R9", 0, 6'd8, 0, 0);

        // freeze with an interrupted settle window
        cyc("R3", 1, 6'd4, 32'd1, 0);
        cyc("R3", 0, 6'd0, 0, 0);
        cyc("R8", 1, 6'd4, 32'd1, 0);
        cyc("R8", 0, 6'd8, 0, 0);
        for (int i = 0; i < SETTLE - 1; i++) cyc("R4", 0, 6'd0, 0, 1);
        cyc("R4", 0, 6'd0, 0, 0);
        for (int i = 0; i < SETTLE; i++) cyc("R4", 0, 6'd0, 0, 1);
        cyc("R4", 0, 6'd0, 0, 1);
        @(negedge clk);
        chk("R4", {31'h0, freeze_out}, 32'h1);
        cyc("R11", 0, 6'd4, 0, 1);

        // region reset while frozen, upper data bits ignored
        cyc("R6", 1, 6'd4, 32'hF000_0002, 1);
        chk("R6", {31'h0, region_rst_out}, 32'h1);
        cyc("R11", 0, 6'd4, 0, 1);
        cyc("R10", 1, 6'd4, 32'd0, 1);
        chk("R10", {31'h0, region_rst_out}, 32'h0);
        cyc("R6", 1, 6'd4, 32'd2, 1);

        // unfreeze ordering
        cyc("R7", 1, 6'd4, 32'd4, 1);
        chk("R7", {30'h0, freeze_out, region_rst_out}, 32'h2);
        cyc("R7", 0, 6'd0, 0, 1);
        chk("R7", {31'h0, freeze_out}, 32'h0);
        cyc("R7", 0, 6'd0, 0, 1);
        cyc("R7", 0, 6'd0, 0, 1);
        cyc("R10", 1, 6'd4, 32'd0, 1);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int          r  = int'($urandom % 10);
            logic        s  = (($urandom % 4) != 0);
            logic [2:0]  v;
            int          pk = int'($urandom % 11);
            case (pk)
                0, 1:    v = 3'd1;
                2, 3:    v = 3'd4;
                4, 5:    v = 3'd2;
                6, 7:    v = 3'd0;
                default: v = 3'($urandom);
            endcase
            if (r < 4)
                cyc("R5", 1, {2'b00, 2'd1, 2'($urandom)}, ($urandom & 32'hFFFF_FFF8) | {29'h0, v}, s);
            else if (r == 4)
                cyc("R9", 1, 6'd8, $urandom, s);
            else
                cyc("R5", 0, 6'($urandom), 0, s);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule